// File: doc/BRIEF.md
# Double-Buffered CAN Receive Frame Holder

This block sits between a CAN protocol engine and a CPU. Each time the engine finishes a correctly received frame, it presents the identifier, the length code and eight data bytes for one cycle. The block keeps two frame registers: a back slot that catches the engine's writes and a front slot that the CPU reads. A frame goes from the back slot to the front slot whenever the front slot is free. When that happens the block raises a full flag, which stays up until the CPU clears it.

The CPU reads the front slot and then writes one to the full-clear input. That releases the slot, and any frame waiting in the back slot moves forward on the next clock. A frame that arrives while both slots are occupied is discarded, and an overrun flag records the loss. Two interrupt requests are offered, each gated by its own enable: a receive request follows the full flag, and an error request follows the overrun flag. A soft reset empties both slots and clears both flags without a full chip reset.

Top module: `can_rx_dbuf`

## Requirements
- R1: After `rst`, `full`, `ovr`, `rx_irq` and `err_irq` are 0 and `rd_id`, `rd_dlc` and `rd_data` are all zero.
- R2: A frame written (`wr_valid` high for one cycle) while both slots are empty appears on the `rd_*` outputs with `full` = 1 at the second rising edge after the write cycle. `full` is still 0 after the first edge.
- R3: While `full` is 1 and not being cleared, the `rd_*` outputs do not change. A frame that arrives meanwhile waits in the back slot.
- R4: A one-cycle pulse on `clr_full` while `full` is 1 drives `full` to 0 after the next edge. If the back slot holds a frame, that frame appears on `rd_*` with `full` = 1 one edge later, so frames are delivered in arrival order.
- R5: A write arriving while the back slot holds a frame and `full` is 1 sets `ovr` at the next edge. The new frame is dropped and both held frames are kept. A `clr_full` in that same cycle does not prevent the overrun.
- R6: `clr_full` and `clr_ovr` are write-one-to-clear pulses. `clr_full` has no effect when `full` is 0. When an overrun and `clr_ovr` fall in the same cycle, `ovr` ends up set.
- R7: `rx_irq` is 1 exactly when `full` = 1 and `rx_ie` = 1.
- R8: `err_irq` is 1 exactly when `ovr` = 1 and `err_ie` = 1.
- R9: Data byte k occupies `rd_data[8k+7:8k]`. Bytes with k >= min(`rd_dlc`, 8) read as zero. The length code is stored unchanged, including values 9 to 15.
- R10: A write that falls in the same cycle as a back-to-front move is accepted into the back slot with no overrun.
- R11: A one-cycle `soft_rst` clears `full` and `ovr` at the next edge and empties both slots. No frame appears afterwards unless a new one is written, and the `rd_*` outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous soft reset: empties slots, clears flags |
| wr_valid | input | 1 | One-cycle strobe: a completed frame is on wr_* |
| wr_id | input | 29 | Identifier of the incoming frame |
| wr_dlc | input | 4 | Length code of the incoming frame |
| wr_data | input | 64 | Incoming data bytes, byte k at bits 8k+7:8k |
| clr_full | input | 1 | Write-one-to-clear for the full flag |
| clr_ovr | input | 1 | Write-one-to-clear for the overrun flag |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rd_id | output | 29 | Front slot identifier |
| rd_dlc | output | 4 | Front slot length code |
| rd_data | output | 64 | Front slot data bytes |
| full | output | 1 | Front slot holds an unread frame |
| ovr | output | 1 | A frame was lost to overrun |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Two operations can share one clock edge: the back slot draining into the front slot, and a new frame arriving from the engine. The bench provokes this by clearing `full` while a frame waits, then writing a new frame in the very next cycle. It judges the outcome by the absence of `ovr` and by both frames reaching `rd_*` in order. A related collision pairs an incoming write with a same-cycle `clr_full` or `clr_ovr` while both slots are full. There the frame must be dropped and `ovr` must end up set.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    parameter int ID_W      = 29;
    parameter int DLC_W     = 4;
    parameter int MAX_BYTES = 8;

    localparam int DATA_W = MAX_BYTES * 8;
    localparam int CNT_W  = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    // number of payload bytes a length code carries, saturating
    function automatic logic [CNT_W-1:0] payload_bytes(input logic [DLC_W-1:0] dlc);
        if (int'(dlc) > MAX_BYTES)
            return CNT_W'(MAX_BYTES);
        return CNT_W'(dlc);
    endfunction

endpackage

// File: rtl/can_rx_trim.sv
module can_rx_trim (
    input  can_rx_pkg::rx_frame_t din,
    output can_rx_pkg::rx_frame_t dout
);
    import can_rx_pkg::*;

    logic [CNT_W-1:0]  n_bytes;
    logic [DATA_W-1:0] kept;

    assign n_bytes = payload_bytes(din.dlc);

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        assign kept[8*b +: 8] = (CNT_W'(b) < n_bytes) ? din.data[8*b +: 8] : 8'h00;
    end

    assign dout = {din.id, din.dlc, kept};
endmodule

// File: rtl/can_rx_slot.sv
module can_rx_slot (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  load,
    input  can_rx_pkg::rx_frame_t din,
    output can_rx_pkg::rx_frame_t dout
);
    always_ff @(posedge clk) begin
        if (rst || flush)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/can_rx_flags.sv
module can_rx_flags (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_full,
    input  logic clr_full,
    input  logic ovr_evt,
    input  logic clr_ovr,
    input  logic rx_ie,
    input  logic err_ie,
    output logic full,
    output logic ovr,
    output logic rx_irq,
    output logic err_irq
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            full <= 1'b0;
        else if (set_full)
            full <= 1'b1;
        else if (clr_full)
            full <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            ovr <= 1'b0;
        else if (ovr_evt)
            ovr <= 1'b1;
        else if (clr_ovr)
            ovr <= 1'b0;
    end

    assign rx_irq  = full & rx_ie;
    assign err_irq = ovr & err_ie;

    // R4
    full_release_chk: assert property (@(posedge clk) disable iff (rst)
        (full && clr_full && !set_full && !soft_rst) |=> !full);

    // R6
    ovr_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && clr_ovr && !ovr_evt && !soft_rst) |=> !ovr);

    // R6
    ovr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_evt && !soft_rst) |=> ovr);

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!full && !ovr));
endmodule

// File: rtl/can_rx_dbuf.sv
module can_rx_dbuf (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            soft_rst,
    input  logic                            wr_valid,
    input  logic [can_rx_pkg::ID_W-1:0]     wr_id,
    input  logic [can_rx_pkg::DLC_W-1:0]    wr_dlc,
    input  logic [can_rx_pkg::DATA_W-1:0]   wr_data,
    input  logic                            clr_full,
    input  logic                            clr_ovr,
    input  logic                            rx_ie,
    input  logic                            err_ie,
    output logic [can_rx_pkg::ID_W-1:0]     rd_id,
    output logic [can_rx_pkg::DLC_W-1:0]    rd_dlc,
    output logic [can_rx_pkg::DATA_W-1:0]   rd_data,
    output logic                            full,
    output logic                            ovr,
    output logic                            rx_irq,
    output logic                            err_irq
);
    import can_rx_pkg::*;

    rx_frame_t in_frame, trimmed, bg_frame, fg_frame;
    logic      bg_valid;
    logic      xfer;
    logic      accept;
    logic      ovr_evt;

    assign in_frame = {wr_id, wr_dlc, wr_data};

    can_rx_trim u_trim (
        .din  (in_frame),
        .dout (trimmed)
    );

    // back slot drains whenever the front slot is free
    assign xfer    = bg_valid & ~full & ~soft_rst;
    assign accept  = wr_valid & (~bg_valid | xfer) & ~soft_rst;
    assign ovr_evt = wr_valid & ~accept & ~soft_rst;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            bg_valid <= 1'b0;
        else if (accept)
            bg_valid <= 1'b1;
        else if (xfer)
            bg_valid <= 1'b0;
    end

    can_rx_slot u_bg (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst),
        .load  (accept),
        .din   (trimmed),
        .dout  (bg_frame)
    );

    can_rx_slot u_fg (
        .clk   (clk),
        .rst   (rst),
        .flush (soft_rst),
        .load  (xfer),
        .din   (bg_frame),
        .dout  (fg_frame)
    );

    can_rx_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_full (xfer),
        .clr_full (clr_full),
        .ovr_evt  (ovr_evt),
        .clr_ovr  (clr_ovr),
        .rx_ie    (rx_ie),
        .err_ie   (err_ie),
        .full     (full),
        .ovr      (ovr),
        .rx_irq   (rx_irq),
        .err_irq  (err_irq)
    );

    assign rd_id   = fg_frame.id;
    assign rd_dlc  = fg_frame.dlc;
    assign rd_data = fg_frame.data;

    // R3
    fg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !clr_full && !soft_rst) |=>
            (full && $stable(rd_id) && $stable(rd_dlc) && $stable(rd_data)));

    // R5
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && bg_valid && full && !soft_rst) |=>
            (ovr && bg_valid && $stable(bg_frame)));

    // R10
    merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && bg_valid && !full && !soft_rst) |=> (full && bg_valid));

    // R2
    arrive_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !bg_valid && !full && !soft_rst) |=> (bg_valid && !full));
endmodule

// File: tb/test_can_rx_dbuf.sv
`timescale 1ns/1ps
module test_can_rx_dbuf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        wr_valid = 1'b0;
    logic [28:0] wr_id = '0;
    logic [3:0]  wr_dlc = '0;
    logic [63:0] wr_data = '0;
    logic        clr_full_d = 1'b0;
    logic        mon_clr = 1'b0;
    logic        clr_ovr = 1'b0;
    logic        rx_ie = 1'b0;
    logic        err_ie = 1'b0;
    logic [28:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic        full, ovr, rx_irq, err_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct packed {
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    can_rx_dbuf i_can_rx_dbuf (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_dlc(wr_dlc), .wr_data(wr_data),
        .clr_full(clr_full_d | mon_clr), .clr_ovr(clr_ovr),
        .rx_ie(rx_ie), .err_ie(err_ie),
        .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .full(full), .ovr(ovr), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    function automatic logic [63:0] trim(input logic [3:0] dlc, input logic [63:0] d);
        logic [63:0] r = '0;
        int n = (dlc > 8) ? 8 : int'(dlc);
        for (int k = 0; k < n; k++) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_fg(input string tag, input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] d);
        logic [63:0] e = trim(dlc, d);
        chk(full && rd_id == id && rd_dlc == dlc && rd_data == e, tag,
            {rd_id, 3'b0, rd_dlc, full, 27'b0}, {id, 3'b0, dlc, 1'b1, 27'b0});
        chk(rd_data == e, tag, rd_data, e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [28:0] id, input logic [3:0] dlc, input logic [63:0] d,
                        input bit with_clr_full, input bit with_clr_ovr);
        wr_valid = 1'b1; wr_id = id; wr_dlc = dlc; wr_data = d;
        clr_full_d = with_clr_full; clr_ovr = with_clr_ovr;
        @(negedge clk);
        wr_valid = 1'b0; clr_full_d = 1'b0; clr_ovr = 1'b0;
    endtask

    task automatic pulse_clr_full;
        clr_full_d = 1'b1; @(negedge clk); clr_full_d = 1'b0;
    endtask

    task automatic pulse_clr_ovr;
        clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    endtask

    // scoreboard monitor: pops the expected frame each time the front slot fills
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && full && !mon_clr) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", {35'b0, rd_id}, 64'h0);
                end else begin
                    e = sb_q.pop_front();
                    chk(rd_id == e.id && rd_dlc == e.dlc, "R4 order/id", {31'b0, rd_dlc, rd_id}, {31'b0, e.dlc, e.id});
                    chk(rd_data == e.data, "R9 scoreboard data", rd_data, e.data);
                end
                mon_clr = 1'b1;
            end else begin
                mon_clr = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1
        chk(!full && !ovr && !rx_irq && !err_irq, "R1 flags", {60'b0, full, ovr, rx_irq, err_irq}, 64'h0);
        chk(rd_id == 0 && rd_dlc == 0 && rd_data == 0, "R1 front slot", rd_data, 64'h0);

        // R2 and R9: short length zeroes upper bytes
        rx_ie = 1'b1;
        send(29'h0ABCDE1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        chk(!full, "R2 not yet full", {63'b0, full}, 64'h0);
        step(1);
        chk_fg("R2/R9 frame A", 29'h0ABCDE1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(rx_irq, "R7 irq enabled", {63'b0, rx_irq}, 64'h1);

        // R3: second frame waits
        send(29'h1000002, 4'd12, 64'h1122_3344_5566_7788, 0, 0);
        step(3);
        chk_fg("R3 front held", 29'h0ABCDE1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rx_ie = 1'b0; #1;
        chk(!rx_irq, "R7 irq masked", {63'b0, rx_irq}, 64'h0);
        rx_ie = 1'b1;

        // R4: release then back slot moves forward
        step(1);
        pulse_clr_full;
        chk(!full, "R4 released", {63'b0, full}, 64'h0);
        step(1);
        chk_fg("R4/R9 frame B len 12", 29'h1000002, 4'd12, 64'h1122_3344_5566_7788);

        // R5: overrun
        send(29'h0000033, 4'd0, 64'hDEAD_BEEF_0000_0001, 0, 0);
        send(29'h0000044, 4'd8, 64'h0102_0304_0506_0708, 0, 0);
        chk(ovr, "R5 overrun set", {63'b0, ovr}, 64'h1);
        chk(!err_irq, "R8 err masked", {63'b0, err_irq}, 64'h0);
        err_ie = 1'b1; #1;
        chk(err_irq, "R8 err enabled", {63'b0, err_irq}, 64'h1);
        step(1);
        chk_fg("R5 front B kept", 29'h1000002, 4'd12, 64'h1122_3344_5566_7788);
        pulse_clr_full;
        step(1);
        chk_fg("R5/R9 frame C len 0", 29'h0000033, 4'd0, 64'hDEAD_BEEF_0000_0001);
        pulse_clr_full;
        step(3);
        chk(!full, "R5 dropped frame never shows", {63'b0, full}, 64'h0);

        // R6: write-one-to-clear
        pulse_clr_ovr;
        chk(!ovr && !err_irq, "R6 ovr cleared", {62'b0, ovr, err_irq}, 64'h0);
        pulse_clr_full;
        step(1);
        chk(!full && rd_id == 29'h0000033, "R6 clr_full on empty", {34'b0, full, rd_id}, {35'b0, 29'h0000033});

        send(29'h0000055, 4'd8, 64'h5555_5555_5555_5555, 0, 0);
        step(1);
        send(29'h0000066, 4'd8, 64'h6666_6666_6666_6666, 0, 0);
        send(29'h0000077, 4'd8, 64'h7777_7777_7777_7777, 0, 1);
        chk(ovr, "R6 set wins over clear", {63'b0, ovr}, 64'h1);
        pulse_clr_ovr;
        chk(!ovr, "R6 ovr cleared again", {63'b0, ovr}, 64'h0);
        send(29'h0000088, 4'd8, 64'h8888_8888_8888_8888, 1, 0);
        chk(ovr && !full, "R5 same-cycle clear no rescue", {62'b0, ovr, full}, 64'h2);
        step(1);
        chk_fg("R5 frame F follows", 29'h0000066, 4'd8, 64'h6666_6666_6666_6666);
        pulse_clr_full;
        step(2);
        chk(!full, "R5 frames G/H dropped", {63'b0, full}, 64'h0);
        pulse_clr_ovr;

        // R10: write on the same edge as back-to-front move
        send(29'h0000099, 4'd2, 64'h0000_0000_0000_A1A2, 0, 0);
        step(1);
        send(29'h00000AA, 4'd4, 64'hFFFF_FFFF_B1B2_B3B4, 0, 0);
        pulse_clr_full;
        send(29'h00000BB, 4'd1, 64'h0000_0000_0000_00C1, 0, 0);
        chk(!ovr, "R10 no overrun", {63'b0, ovr}, 64'h0);
        chk_fg("R10 frame J", 29'h00000AA, 4'd4, 64'hFFFF_FFFF_B1B2_B3B4);
        pulse_clr_full;
        step(1);
        chk_fg("R10 frame K", 29'h00000BB, 4'd1, 64'h0000_0000_0000_00C1);
        pulse_clr_full;

        // R11: soft reset
        send(29'h00000CC, 4'd8, 64'hCCCC_CCCC_CCCC_CCCC, 0, 0);
        step(1);
        send(29'h00000DD, 4'd8, 64'hDDDD_DDDD_DDDD_DDDD, 0, 0);
        send(29'h00000EE, 4'd8, 64'hEEEE_EEEE_EEEE_EEEE, 0, 0);
        soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        chk(!full && !ovr, "R11 flags cleared", {62'b0, full, ovr}, 64'h0);
        step(4);
        chk(!full && rd_id == 0 && rd_data == 0, "R11 slots empty", {34'b0, full, rd_id}, 64'h0);

        // scoreboard burst
        mon_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            exp_t e;
            e.id = 29'($urandom);
            e.dlc = 4'($urandom_range(0, 15));
            e.data = {$urandom, $urandom};
            sb_q.push_back('{id: e.id, dlc: e.dlc, data: trim(e.dlc, e.data)});
            send(e.id, e.dlc, e.data, 0, 0);
            step($urandom_range(2, 4));
        end
        for (int w = 0; w < 50 && sb_q.size() != 0; w++) step(1);
        step(4);
        chk(sb_q.size() == 0, "R4 all frames delivered", 64'(sb_q.size()), 64'h0);
        chk(!ovr, "R5 no spurious overrun", {63'b0, ovr}, 64'h0);
        mon_en = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule